// File: doc/BRIEF.md
# Reorder Buffer with Forwarding

This block keeps instructions in program order while their results arrive in any order. Decode claims a slot at the tail of an eight-entry circular queue and receives a slot tag. It must wait while every slot is taken. A functional unit later returns the result for that tag, together with a store address and an exception flag. The oldest slot leaves the queue only after its result has arrived. A register-type slot then drives a register-file write port, and a store-type slot drives a memory write port. An exception on the oldest slot writes nothing, empties the whole queue in one cycle and starts the trap handler, which gets the faulting PC.

Operand fetch may look up an architectural register number in the queue. The youngest register-type slot that targets that register answers the lookup. It returns its value if the result has arrived, or otherwise its tag, so that the consumer can wait for that producer.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we`, `st_we`, `exc_start` and `lk_hit` are 0.
- R2: An accepted allocation (`alloc_req` and `alloc_ready` both 1 at a rising edge) takes the slot shown on `alloc_tag`. The tag then advances by one modulo 8. With 8 slots in flight, `alloc_ready` is 0 and a request is dropped.
- R3: A completion (`cmp_valid`) writes data, address and exception flag into the slot named by `cmp_tag`, in any order. A completion that names a free slot has no effect on any later output.
- R4: While the oldest slot has no result, nothing retires, even if younger slots have completed. Once the oldest slot has a result without an exception, and is register-type (`alloc_is_store`=0), `rf_we` is 1 in that same cycle with the slot's register and data, and the slot leaves at the next edge.
- R5: A completed store-type oldest slot (`alloc_is_store`=1) drives `st_we` with the completion's address and data, and never `rf_we`.
- R6: A completed oldest slot with the exception flag raises `exc_start` with that slot's PC. In that cycle there is no write, `alloc_ready` is 0 and no allocation is taken. After the next edge the queue is empty and `alloc_tag` is 0.
- R7: An allocation and a retirement in the same cycle both take effect, and occupancy is unchanged.
- R8: A lookup of `lk_reg` matches only valid register-type slots with that destination, and the youngest match wins. `lk_tag` gives that slot. `lk_ready` is 1 with `lk_data` only if that slot has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Decode asks for a slot |
| alloc_is_store | input | 1 | 1 = store-type slot, 0 = register-type |
| alloc_dest | input | 4 | Destination register number |
| alloc_pc | input | 32 | PC of the allocating instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | 3 | Tag of the slot the next allocation takes |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | 3 | Slot being completed |
| cmp_data | input | 32 | Result value or store data |
| cmp_addr | input | 32 | Store address |
| cmp_exc | input | 1 | Completion raised an exception |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write register |
| rf_wdata | output | 32 | Register-file write data |
| st_we | output | 1 | Memory store enable |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data |
| exc_start | output | 1 | Start the exception handler, queue flushed at this edge |
| exc_pc | output | 32 | PC of the faulting instruction |
| lk_reg | input | 4 | Register number to search for |
| lk_hit | output | 1 | A pending producer exists |
| lk_ready | output | 1 | That producer has its value |
| lk_data | output | 32 | Forwarded value |
| lk_tag | output | 3 | Slot of the youngest producer |

## Verification
Two pairs of events can meet in one cycle. In the first, decode allocates while the head retires. The bench forces this by completing the oldest slot and then asserting `alloc_req` during the cycle in which `rf_we` is high. It judges the result by the retire port contents, the tag progression and the occupancy staying constant. In the second, a flush meets a pending allocation and a pile of out-of-order completions behind a trapping head. The bench expects `exc_start` with no write, the allocation refused, and an empty queue with tag 0 afterwards. A behavioural queue model in the bench predicts every output on every cycle.

// File: rtl/rob_pkg.sv
// Package: shared defaults and the head-slot action encoding for the
// reorder buffer. Assumes the depth is a power of two so that slot tags
// wrap naturally.
package rob_pkg;
    localparam int unsigned ROB_DEPTH_DEF = 8;
    localparam int unsigned ROB_REG_W_DEF = 4;
    localparam int unsigned ROB_DATA_W_DEF = 32;
    localparam int unsigned ROB_PC_W_DEF = 32;

    // What the oldest slot does in the current cycle.
    typedef enum logic [1:0] {
        HEAD_WAIT  = 2'd0,
        HEAD_REG   = 2'd1,
        HEAD_STORE = 2'd2,
        HEAD_TRAP  = 2'd3
    } head_act_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
// Module: head/tail pointers and occupancy for the circular slot queue.
// Assumes DEPTH is a power of two (the pointers wrap by overflow) and that
// alloc_fire is never high while full. A flush clears everything in one cycle.
module rob_ptr_ctrl #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic             retire_fire,
    input  logic             flush,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    // Advance the pointers and track the number of slots in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (alloc_fire)
                tail <= tail + 1'b1;
            if (retire_fire)
                head <= head + 1'b1;
            count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
        end
    end

    // The queue is full when every slot is in flight.
    always_comb full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_entry_store.sv
// Module: storage for the reorder buffer slots. Control bits (valid, done,
// exception) are reset and cleared by a flush. Payload fields are written
// only on allocation or completion. A completion to a free slot is dropped.
// Assumes alloc and retire never name the same slot in one cycle.
module rob_entry_store #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned REG_W  = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PC_W   = 32,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_fire,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic              alloc_is_store,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic [DATA_W-1:0] cmp_addr,
    input  logic              cmp_exc,
    input  logic              retire_fire,
    input  logic [IDX_W-1:0]  retire_idx,
    output logic [DEPTH-1:0]  e_valid,
    output logic [DEPTH-1:0]  e_done,
    output logic [DEPTH-1:0]  e_exc,
    output logic [DEPTH-1:0]  e_store,
    output logic [REG_W-1:0]  e_dest [DEPTH],
    output logic [DATA_W-1:0] e_data [DEPTH],
    output logic [DATA_W-1:0] e_addr [DEPTH],
    output logic [PC_W-1:0]   e_pc   [DEPTH]
);
    // Per-slot control bits: allocation, completion, retirement, flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            e_valid <= '0;
            e_done  <= '0;
            e_exc   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_fire && alloc_idx == IDX_W'(i)) begin
                    e_valid[i] <= 1'b1;
                    e_done[i]  <= 1'b0;
                    e_exc[i]   <= 1'b0;
                end else begin
                    if (retire_fire && retire_idx == IDX_W'(i))
                        e_valid[i] <= 1'b0;
                    if (cmp_valid && cmp_idx == IDX_W'(i) && e_valid[i]) begin
                        e_done[i] <= 1'b1;
                        e_exc[i]  <= cmp_exc;
                    end
                end
            end
        end
    end

    // Per-slot payload: static fields at allocation, results at completion.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_fire && alloc_idx == IDX_W'(i)) begin
                e_store[i] <= alloc_is_store;
                e_dest[i]  <= alloc_dest;
                e_pc[i]    <= alloc_pc;
            end
            if (cmp_valid && cmp_idx == IDX_W'(i) && e_valid[i]) begin
                e_data[i] <= cmp_data;
                e_addr[i] <= cmp_addr;
            end
        end
    end
endmodule

// File: rtl/rob_fwd_cam.sv
// Module: associative search of the slots by destination register. Only
// valid register-type slots take part. Among the matches, the slot furthest
// from the head (the youngest) wins. Purely combinational.
module rob_fwd_cam #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned REG_W  = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  e_valid,
    input  logic [DEPTH-1:0]  e_done,
    input  logic [DEPTH-1:0]  e_store,
    input  logic [REG_W-1:0]  e_dest [DEPTH],
    input  logic [DATA_W-1:0] e_data [DEPTH],
    input  logic [IDX_W-1:0]  head,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_hit,
    output logic              lk_ready,
    output logic [DATA_W-1:0] lk_data,
    output logic [IDX_W-1:0]  lk_tag
);
    logic [IDX_W-1:0] best_age;

    // Pick the youngest matching slot by its distance from the head.
    always_comb begin
        lk_hit   = 1'b0;
        best_age = '0;
        lk_tag   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [IDX_W-1:0] age;
            age = IDX_W'(i) - head;
            if (e_valid[i] && !e_store[i] && e_dest[i] == lk_reg &&
                (!lk_hit || age > best_age)) begin
                lk_hit   = 1'b1;
                best_age = age;
                lk_tag   = IDX_W'(i);
            end
        end
    end

    // Value and readiness of the winning slot.
    always_comb begin
        lk_ready = lk_hit && e_done[lk_tag];
        lk_data  = e_data[lk_tag];
    end
endmodule

// File: rtl/rob_core.sv
// Module: reorder buffer top. Completion is out of order, retirement is in
// order. The head slot is decoded into a single action per cycle: wait,
// register write, store, or trap (flush). The retire ports are
// combinational from the head slot and the slot leaves at the next edge.
// Assumes DEPTH is a power of two.
module rob_core
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH  = ROB_DEPTH_DEF,
    parameter int unsigned REG_W  = ROB_REG_W_DEF,
    parameter int unsigned DATA_W = ROB_DATA_W_DEF,
    parameter int unsigned PC_W   = ROB_PC_W_DEF,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              alloc_is_store,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_tag,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_tag,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic [DATA_W-1:0] cmp_addr,
    input  logic              cmp_exc,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              st_we,
    output logic [DATA_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic              exc_start,
    output logic [PC_W-1:0]   exc_pc,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_hit,
    output logic              lk_ready,
    output logic [DATA_W-1:0] lk_data,
    output logic [IDX_W-1:0]  lk_tag
);
    logic [IDX_W-1:0]  head;
    logic [IDX_W-1:0]  tail;
    logic [CNT_W-1:0]  occupancy;
    logic              full;
    logic              alloc_fire;
    logic              retire_fire;
    logic              flush;
    head_act_e         head_act;

    logic [DEPTH-1:0]  e_valid;
    logic [DEPTH-1:0]  e_done;
    logic [DEPTH-1:0]  e_exc;
    logic [DEPTH-1:0]  e_store;
    logic [REG_W-1:0]  e_dest [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic [DATA_W-1:0] e_addr [DEPTH];
    logic [PC_W-1:0]   e_pc   [DEPTH];

    // Decide what the oldest slot does this cycle.
    always_comb begin
        head_act = HEAD_WAIT;
        if (e_valid[head] && e_done[head]) begin
            if (e_exc[head])
                head_act = HEAD_TRAP;
            else if (e_store[head])
                head_act = HEAD_STORE;
            else
                head_act = HEAD_REG;
        end
    end

    // Derive the handshakes from the head action and the occupancy.
    always_comb begin
        flush       = (head_act == HEAD_TRAP);
        retire_fire = (head_act == HEAD_REG) || (head_act == HEAD_STORE);
        alloc_ready = !full && !flush;
        alloc_fire  = alloc_req && alloc_ready;
        alloc_tag   = tail;
    end

    // Drive the architectural write ports and the trap start from the head.
    always_comb begin
        rf_we     = (head_act == HEAD_REG);
        rf_waddr  = e_dest[head];
        rf_wdata  = e_data[head];
        st_we     = (head_act == HEAD_STORE);
        st_addr   = e_addr[head];
        st_data   = e_data[head];
        exc_start = flush;
        exc_pc    = e_pc[head];
    end

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_fire  (alloc_fire),
        .retire_fire (retire_fire),
        .flush       (flush),
        .head        (head),
        .tail        (tail),
        .count       (occupancy),
        .full        (full)
    );

    rob_entry_store #(
        .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .alloc_fire     (alloc_fire),
        .alloc_idx      (tail),
        .alloc_is_store (alloc_is_store),
        .alloc_dest     (alloc_dest),
        .alloc_pc       (alloc_pc),
        .cmp_valid      (cmp_valid),
        .cmp_idx        (cmp_tag),
        .cmp_data       (cmp_data),
        .cmp_addr       (cmp_addr),
        .cmp_exc        (cmp_exc),
        .retire_fire    (retire_fire),
        .retire_idx     (head),
        .e_valid        (e_valid),
        .e_done         (e_done),
        .e_exc          (e_exc),
        .e_store        (e_store),
        .e_dest         (e_dest),
        .e_data         (e_data),
        .e_addr         (e_addr),
        .e_pc           (e_pc)
    );

    rob_fwd_cam #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_cam (
        .e_valid  (e_valid),
        .e_done   (e_done),
        .e_store  (e_store),
        .e_dest   (e_dest),
        .e_data   (e_data),
        .head     (head),
        .lk_reg   (lk_reg),
        .lk_hit   (lk_hit),
        .lk_ready (lk_ready),
        .lk_data  (lk_data),
        .lk_tag   (lk_tag)
    );
endmodule

// File: rtl/rob_core_chk.sv
// Checker: temporal properties of the reorder buffer, bound to rob_core.
module rob_core_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_req,
    input logic             alloc_ready,
    input logic [IDX_W-1:0] alloc_tag,
    input logic             rf_we,
    input logic             st_we,
    input logic             exc_start,
    input logic             lk_hit,
    input logic             lk_ready,
    input logic [CNT_W-1:0] occupancy
);
    // R4
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, st_we, exc_start}));

    // R5
    store_not_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> !rf_we);

    // R2
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == CNT_W'(DEPTH)) |-> !alloc_ready);

    // R2
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_ready) |=> (alloc_tag == IDX_W'($past(alloc_tag) + 1'b1)));

    // R6
    trap_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |-> !alloc_ready);

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |=> (occupancy == '0 && alloc_tag == '0 && !lk_hit && !exc_start));

    // R7
    occ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_ready && (rf_we || st_we)) |=> (occupancy == $past(occupancy)));

    // R8
    ready_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ready |-> lk_hit);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_req   (alloc_req),
    .alloc_ready (alloc_ready),
    .alloc_tag   (alloc_tag),
    .rf_we       (rf_we),
    .st_we       (st_we),
    .exc_start   (exc_start),
    .lk_hit      (lk_hit),
    .lk_ready    (lk_ready),
    .occupancy   (occupancy)
);

// File: tb/rob_core_test.sv
`timescale 1ns/100ps
module rob_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req, alloc_is_store;
    logic [3:0]  alloc_dest;
    logic [31:0] alloc_pc;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        cmp_valid, cmp_exc;
    logic [2:0]  cmp_tag;
    logic [31:0] cmp_data, cmp_addr;
    logic        rf_we, st_we, exc_start;
    logic [3:0]  rf_waddr;
    logic [31:0] rf_wdata, st_addr, st_data, exc_pc;
    logic [3:0]  lk_reg;
    logic        lk_hit, lk_ready;
    logic [31:0] lk_data;
    logic [2:0]  lk_tag;

    int vectors = 0;
    int errors = 0;
    bit done_flag = 0;

    // Behavioural model: program-order queue of slot tags plus slot contents.
    int          order[$];
    int          next_tag = 0;
    bit          m_valid[8], m_done[8], m_exc[8], m_st[8];
    logic [3:0]  m_dest[8];
    logic [31:0] m_data[8], m_addr[8], m_pc[8];

    always #2.5 clk = ~clk;

    rob_core uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_is_store(alloc_is_store),
        .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
        .cmp_addr(cmp_addr), .cmp_exc(cmp_exc),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
        .exc_start(exc_start), .exc_pc(exc_pc),
        .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_ready(lk_ready),
        .lk_data(lk_data), .lk_tag(lk_tag)
    );

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_req = 0; alloc_is_store = 0; alloc_dest = 0; alloc_pc = 0;
        cmp_valid = 0; cmp_tag = 0; cmp_data = 0; cmp_addr = 0; cmp_exc = 0;
        lk_reg = 0;
    endtask

    // Compare every output with the model, cross one edge, update the model.
    task automatic tick();
        bit e_exc, e_rf, e_st, e_ready, e_hit;
        int h, hit_tag;
        #1;
        e_exc = 0; e_rf = 0; e_st = 0; e_hit = 0; h = 0; hit_tag = 0;
        if (order.size() > 0) begin
            h = order[0];
            if (m_done[h]) begin
                if (m_exc[h]) e_exc = 1;
                else if (m_st[h]) e_st = 1;
                else e_rf = 1;
            end
        end
        e_ready = (order.size() != 8) && !e_exc;
        cmp("R6", "exc_start", exc_start, e_exc);
        if (e_exc) cmp("R6", "exc_pc", exc_pc, m_pc[h]);
        cmp("R2", "alloc_ready", alloc_ready, e_ready);
        cmp("R2", "alloc_tag", alloc_tag, next_tag);
        cmp("R4", "rf_we", rf_we, e_rf);
        if (e_rf) begin
            cmp("R4", "rf_waddr", rf_waddr, m_dest[h]);
            cmp("R4", "rf_wdata", rf_wdata, m_data[h]);
        end
        cmp("R5", "st_we", st_we, e_st);
        if (e_st) begin
            cmp("R5", "st_addr", st_addr, m_addr[h]);
            cmp("R5", "st_data", st_data, m_data[h]);
        end
        for (int k = order.size() - 1; k >= 0; k--)
            if (!e_hit && !m_st[order[k]] && m_dest[order[k]] == lk_reg) begin
                e_hit = 1; hit_tag = order[k];
            end
        cmp("R8", "lk_hit", lk_hit, e_hit);
        if (e_hit) begin
            cmp("R8", "lk_tag", lk_tag, hit_tag);
            cmp("R8", "lk_ready", lk_ready, m_done[hit_tag]);
            if (m_done[hit_tag]) cmp("R8", "lk_data", lk_data, m_data[hit_tag]);
        end
        @(posedge clk);
        if (e_exc) begin
            for (int i = 0; i < 8; i++) m_valid[i] = 0;
            order.delete();
            next_tag = 0;
        end else begin
            if (cmp_valid && m_valid[cmp_tag]) begin
                m_done[cmp_tag] = 1; m_exc[cmp_tag] = cmp_exc;
                m_data[cmp_tag] = cmp_data; m_addr[cmp_tag] = cmp_addr;
            end
            if (e_rf || e_st) begin
                m_valid[order[0]] = 0;
                void'(order.pop_front());
            end
            if (alloc_req && e_ready) begin
                m_valid[next_tag] = 1; m_done[next_tag] = 0; m_exc[next_tag] = 0;
                m_st[next_tag] = alloc_is_store; m_dest[next_tag] = alloc_dest;
                m_pc[next_tag] = alloc_pc;
                order.push_back(next_tag);
                next_tag = (next_tag + 1) % 8;
            end
        end
        @(negedge clk);
    endtask

    task automatic put(bit st, logic [3:0] d, logic [31:0] pc);
        alloc_req = 1; alloc_is_store = st; alloc_dest = d; alloc_pc = pc;
    endtask

    task automatic fin(logic [2:0] t, logic [31:0] d, logic [31:0] a, bit e);
        cmp_valid = 1; cmp_tag = t; cmp_data = d; cmp_addr = a; cmp_exc = e;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        cmp("R1", "alloc_ready", alloc_ready, 1);
        cmp("R1", "alloc_tag", alloc_tag, 0);
        cmp("R1", "rf_we", rf_we, 0);
        cmp("R1", "st_we", st_we, 0);
        cmp("R1", "exc_start", exc_start, 0);
        cmp("R1", "lk_hit", lk_hit, 0);

        put(0, 4'd3, 32'h100); tick();
        put(0, 4'd5, 32'h104); tick();
        put(0, 4'd3, 32'h108); lk_reg = 3; tick();
        put(1, 4'd3, 32'h10c); lk_reg = 3; tick();
        idle(); lk_reg = 3; #1;
        cmp("R8", "youngest r3 tag", lk_tag, 2);
        cmp("R8", "youngest r3 not ready", lk_ready, 0);
        tick();

        fin(3'd2, 32'h0000_00C2, 0, 0); lk_reg = 3; tick();
        idle(); lk_reg = 3; #1;
        cmp("R3", "out-of-order result forwarded", lk_data, 32'hC2);
        tick();
        fin(3'd1, 32'h0000_00B1, 0, 0); tick();
        idle(); #1;
        cmp("R4", "head pending blocks retire", rf_we, 0);
        tick();
        fin(3'd0, 32'h0000_00A0, 0, 0); tick();

        idle(); put(0, 4'd7, 32'h110); #1;
        cmp("R7", "retire in alloc cycle", rf_we, 1);
        cmp("R7", "alloc in retire cycle", alloc_ready, 1);
        tick();
        idle(); tick(); tick();
        #1;
        cmp("R5", "store waits for data", st_we, 0);
        fin(3'd3, 32'h0000_00D0, 32'h40, 0); tick();
        idle(); #1;
        cmp("R5", "store retire", st_we, 1);
        cmp("R5", "store addr", st_addr, 32'h40);
        cmp("R5", "no reg write on store", rf_we, 0);
        tick();
        #1;
        cmp("R7", "occupancy kept by simultaneous alloc", alloc_tag, 5);

        for (int k = 0; k < 10; k++) begin
            idle(); put(0, 4'(k), 32'h200 + 32'(k) * 4); lk_reg = 4'(k); tick();
        end
        idle(); #1;
        cmp("R2", "full blocks alloc", alloc_ready, 0);
        cmp("R2", "tail unchanged when full", alloc_tag, 4);
        for (int k = 7; k >= 1; k--) begin
            idle(); fin(3'((4 + k) % 8), 32'h1000 + 32'(k), 0, 0); lk_reg = 4'(k); tick();
        end
        idle(); #1;
        cmp("R4", "younger done, head not", rf_we, 0);
        fin(3'd4, 32'hDEAD, 0, 1); tick();
        idle(); put(0, 4'd9, 32'h300); fin(3'd6, 32'h66, 0, 0); #1;
        cmp("R6", "trap start", exc_start, 1);
        cmp("R6", "trap pc", exc_pc, 32'h110);
        cmp("R6", "no write on trap", rf_we, 0);
        cmp("R6", "no alloc on trap", alloc_ready, 0);
        tick();
        idle(); lk_reg = 7; #1;
        cmp("R6", "empty after flush tag", alloc_tag, 0);
        cmp("R6", "empty after flush lookup", lk_hit, 0);
        tick();

        idle(); fin(3'd5, 32'h55, 32'h55, 0); tick();
        for (int k = 0; k < 6; k++) begin
            idle(); put(0, 4'd9, 32'h400 + 32'(k) * 4); tick();
        end
        idle(); lk_reg = 9; #1;
        cmp("R3", "free-slot completion ignored (tag)", lk_tag, 5);
        cmp("R3", "free-slot completion ignored (ready)", lk_ready, 0);
        tick();
        for (int k = 5; k >= 0; k--) begin
            idle(); fin(3'(k), 32'h9000 + 32'(k), 0, 0); lk_reg = 9; tick();
        end
        idle(); lk_reg = 9;
        repeat (8) tick();

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule